// File: doc/BRIEF.md
# Flash Toggle-Status Bit Generator

This block sits on the device side of a flash array. It decides what a read returns while an internal program or erase runs. In that state a read gets a status word rather than array contents. Bit 6 of the status word is a global busy toggle: it flips on every read while an operation is active, so the host sees two reads that differ. Bit 2 is a sector-local toggle: it flips only when the read falls inside a sector that is marked for erase. A host uses the two bits together to tell an active erase apart from an erase that has been suspended.

The operation engine supplies a busy level, an erase-suspend level and a per-sector erase-select mask. The command decoder supplies an accept pulse with the command class and the target sector. A program aimed at a protected sector has no real work to do. The same holds for an erase whose selected sectors are all protected. For these two cases the block runs its own counter and toggles bit 6 for a fixed window: about 1 µs for the program, about 100 µs for the erase. After the window, reads return array data again. A read event comes from an active-low read-control line. In the asynchronous variant this is the combined output-enable/chip-enable; in the synchronous variant it is the address-valid strobe.

Top module: `flash_toggle_status`

## Requirements
- R1: While `eng_busy`=1, each read event at any sector returns a status word. Bit 6 of that word is the global toggle, bit 2 is the sector toggle, and every other bit is 0. The global toggle inverts after each such read.
- R2: When the block is not in status mode, a read returns `array_data` as it was sampled at the read event.
- R3: With `erase_susp`=1 and `eng_busy`=0, a read in an erase-selected sector returns the status word with bit 6 held unchanged. A read in any other sector returns array data.
- R4: With `erase_susp`=1 and `eng_busy`=1 (a program running inside suspend), bit 6 inverts on every read again.
- R5: Bit 2 inverts on a read only when `erase_sel` has the read sector's bit set and either `eng_busy` or `erase_susp` is 1. Otherwise bit 2 holds.
- R6: An accepted program command (`cmd_kind`=1) whose target sector has its `prot_mask` bit set starts a window of CLK_MHZ×SHORT_US cycles. During the window reads return the toggling status word. After it, reads return array data.
- R7: An accepted erase command (`cmd_kind`=2) starts a window of CLK_MHZ×LONG_US cycles when `erase_sel` is nonzero and every selected sector is protected. The window behaves as in R6.
- R8: An accepted erase with at least one selected, unprotected sector starts no window. An accepted command of any other kind cancels a running window.
- R9: Each accepted command resets both toggle bits to 0, so the first status read after it shows bits 6 and 2 as 0.
- R10: In the asynchronous variant, a read event is a falling edge of `rd_ctl_n`. Holding the line low yields exactly one event.
- R11: In the synchronous variant, there is a read event on each clock while `rd_ctl_n` is low, and one more on the clock that samples its rising edge.
- R12: After reset, `rd_valid`=0 and `rd_data`=0. `rd_valid` pulses for one cycle, one clock after each read event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_busy | input | 1 | Program or erase algorithm actively running |
| erase_susp | input | 1 | Erase is suspended |
| erase_sel | input | NUM_SECTORS | Sectors marked for the current erase |
| prot_mask | input | NUM_SECTORS | Protected sectors |
| cmd_acc | input | 1 | One-cycle pulse: a command was accepted |
| cmd_kind | input | 2 | 0 other, 1 program, 2 erase |
| cmd_sector | input | SEC_W | Target sector of a program command |
| rd_ctl_n | input | 1 | Active-low read control (OE/CE, or address-valid in sync mode) |
| rd_sector | input | SEC_W | Sector of the read address |
| array_data | input | DATA_W | Array contents at the read address |
| rd_valid | output | 1 | Read data updated this cycle |
| rd_data | output | DATA_W | Status word or array data for the last read |

## Verification
The bench runs a sequence of reads through active erase, suspend, program inside suspend and idle. Along the way it checks that the status word switches to array data per sector during suspend; a design that keeps reporting status for unselected sectors would show zeros where array data belongs. The two protect windows are each read a few cycles before and a few cycles after their expiry. A counter that was off by a large amount, or that was loaded with the wrong length, would therefore return the wrong kind of word. The bench also counts read events while the control line is held low, in both variants. This separates a level detector from an edge detector. It also confirms that an accept pulse clears toggle state left over from earlier reads.

// File: rtl/fst_pkg.sv
package fst_pkg;
   typedef enum logic [1:0] {
      CMD_OTHER   = 2'd0,
      CMD_PROGRAM = 2'd1,
      CMD_ERASE   = 2'd2
   } cmd_kind_e;

   localparam int GLOBAL_BIT = 6;
   localparam int SECTOR_BIT = 2;
   localparam int N_TOGGLES  = 2;
endpackage

// File: rtl/fst_read_event.sv
module fst_read_event #(
   parameter bit SYNC_MODE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_n,
   output logic ev
);
   logic ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= 1'b1;
      else        ctl_q <= ctl_n;
   end

   generate
      if (SYNC_MODE) begin : g_sync
         // event on every clock while low, plus the clock that samples the rise
         assign ev = !ctl_n || !ctl_q;
      end else begin : g_async
         assign ev = ctl_q && !ctl_n;

         assert_one_shot_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ev |=> !ev);
      end
   endgenerate
endmodule

// File: rtl/fst_pseudo_timer.sv
module fst_pseudo_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             active
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);

   assert_window_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val));
   assert_window_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load) |=> cnt_q == $past(cnt_q) - 1'b1);
   assert_window_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> !active);
endmodule

// File: rtl/fst_toggle_cell.sv
module fst_toggle_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flip,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (clr)  q <= 1'b0;
      else if (flip) q <= ~q;
   end

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !q);
   assert_invert_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (flip && !clr) |=> q != $past(q));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flip && !clr) |=> $stable(q));
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
   import fst_pkg::*;
#(
   parameter int NUM_SECTORS = 8,
   parameter int DATA_W      = 8,
   parameter int CLK_MHZ     = 200,
   parameter int SHORT_US    = 1,
   parameter int LONG_US     = 100,
   parameter bit SYNC_MODE   = 1'b0,
   localparam int SEC_W      = $clog2(NUM_SECTORS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   eng_busy,
   input  logic                   erase_susp,
   input  logic [NUM_SECTORS-1:0] erase_sel,
   input  logic [NUM_SECTORS-1:0] prot_mask,
   input  logic                   cmd_acc,
   input  logic [1:0]             cmd_kind,
   input  logic [SEC_W-1:0]       cmd_sector,
   input  logic                   rd_ctl_n,
   input  logic [SEC_W-1:0]       rd_sector,
   input  logic [DATA_W-1:0]      array_data,
   output logic                   rd_valid,
   output logic [DATA_W-1:0]      rd_data
);
   localparam int SHORT_CYC = CLK_MHZ * SHORT_US;
   localparam int LONG_CYC  = CLK_MHZ * LONG_US;
   localparam int CNT_W     = $clog2(LONG_CYC + 1);
   localparam logic [DATA_W-1:0] STATUS_MASK =
      DATA_W'((1 << GLOBAL_BIT) | (1 << SECTOR_BIT));

   initial begin
      assert (NUM_SECTORS >= 2 && (1 << SEC_W) == NUM_SECTORS)
         else $error("NUM_SECTORS must be a power of two, at least 2");
      assert (DATA_W >= 8) else $error("DATA_W must hold bit 6");
      assert (SHORT_CYC >= 1 && LONG_CYC >= SHORT_CYC)
         else $error("window lengths inconsistent");
   end

   // ---------------- read event ----------------
   logic rd_ev;
   fst_read_event #(.SYNC_MODE(SYNC_MODE)) u_rev (
      .clk(clk), .rst_n(rst_n), .ctl_n(rd_ctl_n), .ev(rd_ev));

   // ---------------- protected-command window ----------------
   logic             cmd_prot_hit;
   logic             all_sel_prot;
   logic [CNT_W-1:0] win_len;
   logic             pseudo_busy;

   assign cmd_prot_hit = prot_mask[cmd_sector];
   assign all_sel_prot = (erase_sel != '0) && ((erase_sel & ~prot_mask) == '0);

   always_comb begin
      win_len = '0;
      if (cmd_kind == CMD_PROGRAM && cmd_prot_hit)   win_len = CNT_W'(SHORT_CYC);
      else if (cmd_kind == CMD_ERASE && all_sel_prot) win_len = CNT_W'(LONG_CYC);
   end

   fst_pseudo_timer #(.CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .load(cmd_acc), .load_val(win_len),
      .active(pseudo_busy));

   // ---------------- toggle cells ----------------
   logic sel_hit;
   logic status_mode;
   logic [N_TOGGLES-1:0] tog_en;
   logic [N_TOGGLES-1:0] tog_q;

   assign sel_hit     = erase_sel[rd_sector];
   assign status_mode = eng_busy || pseudo_busy || (erase_susp && sel_hit);
   assign tog_en[0]   = eng_busy || pseudo_busy;                 // global bit
   assign tog_en[1]   = (eng_busy || erase_susp) && sel_hit;     // sector bit

   generate
      for (genvar i = 0; i < N_TOGGLES; i++) begin : g_tog
         fst_toggle_cell u_cell (
            .clk(clk), .rst_n(rst_n), .clr(cmd_acc),
            .flip(rd_ev && tog_en[i]), .q(tog_q[i]));
      end
   endgenerate

   // ---------------- output word ----------------
   logic [DATA_W-1:0] status_word;
   always_comb begin
      status_word             = '0;
      status_word[GLOBAL_BIT] = tog_q[0];
      status_word[SECTOR_BIT] = tog_q[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_ev;
         if (rd_ev) rd_data <= status_mode ? status_word : array_data;
      end
   end

   assert_array_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev && !status_mode) |=> rd_data == $past(array_data));
   assert_zero_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev && status_mode) |=> (rd_data & ~STATUS_MASK) == '0);
   assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_ev) |-> !rd_valid);
   assert_sector_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev && !sel_hit && !cmd_acc) |=> $stable(tog_q[1]));
endmodule

// File: tb/sim_flash_toggle_status.sv
module sim_flash_toggle_status;
   localparam int NS = 8;
   localparam int SW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eng_busy = 1'b0, erase_susp = 1'b0;
   logic [NS-1:0] erase_sel = 8'b0000_1100;
   logic [NS-1:0] prot_mask = 8'b1000_0001;
   logic cmd_acc = 1'b0;
   logic [1:0] cmd_kind = 2'd0;
   logic [SW-1:0] cmd_sector = '0;
   logic rd_ctl_n = 1'b1, rd_ctl1_n = 1'b1;
   logic [SW-1:0] rd_sector = '0;
   logic [7:0] array_data;
   logic rv0, rv1;
   logic [7:0] rd0, rd1;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;
   assign array_data = 8'hA0 | {5'b0, rd_sector};

   flash_toggle_status u0 (
      .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .erase_susp(erase_susp),
      .erase_sel(erase_sel), .prot_mask(prot_mask), .cmd_acc(cmd_acc),
      .cmd_kind(cmd_kind), .cmd_sector(cmd_sector), .rd_ctl_n(rd_ctl_n),
      .rd_sector(rd_sector), .array_data(array_data),
      .rd_valid(rv0), .rd_data(rd0));

   flash_toggle_status #(.SYNC_MODE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .erase_susp(erase_susp),
      .erase_sel(erase_sel), .prot_mask(prot_mask), .cmd_acc(cmd_acc),
      .cmd_kind(cmd_kind), .cmd_sector(cmd_sector), .rd_ctl_n(rd_ctl1_n),
      .rd_sector(rd_sector), .array_data(array_data),
      .rd_valid(rv1), .rd_data(rd1));

   // {busy, susp, sector, expected word}
   localparam int NV = 12;
   localparam logic [12:0] VEC [NV] = '{
      {1'b1, 1'b0, 3'd0, 8'h00},  // R1 status, sector bit unselected
      {1'b1, 1'b0, 3'd2, 8'h40},  // R1 R5
      {1'b1, 1'b0, 3'd3, 8'h04},  // R1 R5
      {1'b1, 1'b0, 3'd5, 8'h40},  // R1 any address
      {1'b0, 1'b1, 3'd2, 8'h00},  // R3 global held
      {1'b0, 1'b1, 3'd3, 8'h04},  // R3 R5 sector bit under suspend
      {1'b0, 1'b1, 3'd5, 8'hA5},  // R3 unselected gives array
      {1'b1, 1'b1, 3'd5, 8'h00},  // R4 program in suspend
      {1'b1, 1'b1, 3'd2, 8'h40},  // R4
      {1'b1, 1'b1, 3'd6, 8'h04},  // R4 R5
      {1'b0, 1'b0, 3'd2, 8'hA2},  // R2 idle
      {1'b0, 1'b0, 3'd7, 8'hA7}   // R2 idle
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [SW-1:0] sec, output logic [7:0] val);
      @(negedge clk);
      rd_sector = sec;
      rd_ctl_n  = 1'b0;
      @(negedge clk);
      val      = rd0;
      rd_ctl_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_cmd(input logic [1:0] kind, input logic [SW-1:0] sec);
      @(negedge clk);
      cmd_acc = 1'b1; cmd_kind = kind; cmd_sector = sec;
      @(negedge clk);
      cmd_acc = 1'b0; cmd_kind = 2'd0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int cnt;
      repeat (3) @(negedge clk);
      chk("R12 reset valid", {7'b0, rv0}, 8'h00);
      chk("R12 reset data", rd0, 8'h00);
      rst_n = 1'b1;

      // erase with unprotected selected sectors: no pseudo window
      do_cmd(2'd2, 3'd0);
      for (int i = 0; i < NV; i++) begin
         eng_busy   = VEC[i][12];
         erase_susp = VEC[i][11];
         do_read(VEC[i][10:8], v);
         chk($sformatf("R1-table step %0d", i), v, VEC[i][7:0]);
      end

      // R9: accept pulse clears both toggles (state was bit6=1, bit2=1)
      eng_busy = 1'b1;
      do_cmd(2'd2, 3'd0);
      do_read(3'd2, v);
      chk("R9 cleared", v, 8'h00);

      // R10: held-low control gives one event
      cnt = 0;
      @(negedge clk);
      rd_sector = 3'd2; rd_ctl_n = 1'b0;
      repeat (3) begin @(negedge clk); cnt += int'(rv0); end
      v = rd0;
      rd_ctl_n = 1'b1;
      repeat (2) begin @(negedge clk); cnt += int'(rv0); end
      chk("R10 event count", 8'(cnt), 8'd1);
      chk("R10 data", v, 8'h44);
      do_read(3'd2, v);
      chk("R10 single toggle", v, 8'h00);

      // R11: sync variant, 3 low clocks plus the rise
      cnt = 0;
      @(negedge clk);
      rd_ctl1_n = 1'b0;
      repeat (3) begin @(negedge clk); cnt += int'(rv1); end
      rd_ctl1_n = 1'b1;
      repeat (2) begin @(negedge clk); cnt += int'(rv1); end
      chk("R11 sync event count", 8'(cnt), 8'd4);

      // R8: erase with unprotected selection, idle engine -> array
      eng_busy = 1'b0;
      do_cmd(2'd2, 3'd0);
      do_read(3'd4, v);
      chk("R8 no window", v, 8'hA4);

      // R6: program to protected sector 0
      do_cmd(2'd1, 3'd0);
      do_read(3'd4, v);
      chk("R6 window first", v, 8'h00);
      do_read(3'd4, v);
      chk("R6 window toggles", v, 8'h40);
      repeat (185) @(negedge clk);
      do_read(3'd4, v);
      chk("R6 window near end", v, 8'h00);
      repeat (10) @(negedge clk);
      do_read(3'd4, v);
      chk("R6 after window", v, 8'hA4);

      // R7: erase where every selected sector is protected
      erase_sel = 8'b1000_0001;
      do_cmd(2'd2, 3'd0);
      do_read(3'd4, v);
      chk("R7 window first", v, 8'h00);
      repeat (19980) @(negedge clk);
      do_read(3'd4, v);
      chk("R7 window near end", v, 8'h40);
      repeat (20) @(negedge clk);
      do_read(3'd4, v);
      chk("R7 after window", v, 8'hA4);
      erase_sel = 8'b0000_1100;

      // R8: other command cancels a running window
      do_cmd(2'd1, 3'd7);
      do_cmd(2'd0, 3'd0);
      do_read(3'd4, v);
      chk("R8 cancel", v, 8'hA4);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule